// File: doc/BRIEF.md
# GateA20 Command Sequencer

This block sits behind the host-side decoder of a legacy keyboard-controller channel. It receives completed host I/O writes as a single-cycle strobe with a 16-bit port address and an 8-bit data byte. The strobe is raised once the bus cycle, including its turnaround and handshake phases, has finished. Writes to the command port and the data port are latched into an input buffer. They set or clear a command/data flag and normally raise a buffer-full flag with a one-cycle interrupt pulse. The local controller clears the buffer-full flag by reading the buffer.

When the local controller has set the enable bit, the block intercepts one pair of writes in hardware: command 0xD1, then the next data-port byte. Bit 1 of that byte becomes the GateA20 output. Neither write of the pair raises the buffer-full flag or the interrupt. The block also gives a pin-function select that hands the shared pin to GateA20. The bus reset forces the output low, drops the pin back to port use and discards a half-finished sequence. It leaves the enable bit unchanged.

Top module: `kbc_gate_a20`

## Requirements
- R1: After power-on reset (rst_n low) the control register reads 0x00, a20_out is 1, ibf, ibf_irq and a20_sel are 0, and no sequence is pending.
- R2: A local write (cpu_wr) stores cpu_wdata bit 0 as the enable bit. cpu_rdata returns the enable bit in bit 0, and bits 7:1 always read 0 whatever value was written.
- R3: a20_sel is 1 exactly when the enable bit is 1 and lreset_n is high.
- R4: With the enable bit set, a write of 0xD1 to port 0x64 followed by a write to port 0x60 sets a20_out to bit 1 of the 0x60 data. The new value is visible in the cycle after the data strobe.
- R5: Each write to 0x64 or 0x60 loads ibuf_data with the byte. cmd_flag becomes 1 on a 0x64 write and 0 on a 0x60 write, and this includes both writes of a GateA20 pair. Neither write of the pair sets ibf or pulses ibf_irq.
- R6: a20_out keeps its value until the data byte of a later 0xD1 pair arrives. A 0x60 write with no pending 0xD1 leaves it unchanged.
- R7: A 0x64 write of any value other than 0xD1 cancels a pending sequence. Like every normal write, it sets ibf and pulses ibf_irq high for exactly one cycle.
- R8: While the enable bit is 0, every 0x64/0x60 write is a normal write and a20_out does not change.
- R9: While lreset_n is low, a20_out is forced to 0, any pending sequence is cleared, host writes are ignored and the enable bit is kept. After lreset_n returns high, a20_sel follows the enable bit again.
- R10: cpu_ibuf_rd clears ibf in the next cycle. When a normal host write arrives in the same cycle, setting wins.
- R11: Host writes to addresses other than 0x60 and 0x64 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| lreset_n | input | 1 | Host bus reset, active low |
| hwr_valid | input | 1 | One-cycle strobe for a completed host I/O write |
| hwr_addr | input | 16 | Host I/O port address |
| hwr_data | input | 8 | Host write data |
| cpu_wr | input | 1 | Local write to the control register |
| cpu_wdata | input | 8 | Control register write data |
| cpu_ibuf_rd | input | 1 | Local read of the input buffer, clears ibf |
| cpu_rdata | output | 8 | Control register read value |
| ibuf_data | output | 8 | Input buffer contents |
| cmd_flag | output | 1 | 1 = last byte came to the command port |
| ibf | output | 1 | Input buffer full |
| ibf_irq | output | 1 | One-cycle buffer-full interrupt request |
| a20_sel | output | 1 | Pin function select: 1 = GateA20 drives the pin |
| a20_out | output | 1 | GateA20 value |

## Verification
The assertions assume that hwr_valid stands for one completed write per strobe and that rst_n is applied before any traffic. They also assume the stimulus never raises hwr_valid while lreset_n is low. The bench applies at most one host write, one local write and one buffer read in each cycle, always one cycle apart. It drops host strobes during its bus-reset pulses. Random operations pick from the two decoded ports, unrelated addresses, 0xD1 and other command bytes, enable toggles and reset pulses. This mix keeps pending sequences, cancellations and disabled-mode writes interleaved.

// File: rtl/kbc_gate_a20.sv
module kbc_gate_a20 #(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] CMD_PORT  = 16'h0064,
  parameter logic [15:0] DATA_PORT = 16'h0060,
  parameter logic [7:0]  A20_CMD   = 8'hD1,
  parameter int          A20_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreset_n,
  input  logic          hwr_valid,
  input  logic [AW-1:0] hwr_addr,
  input  logic [DW-1:0] hwr_data,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_ibuf_rd,
  output logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] ibuf_data,
  output logic          cmd_flag,
  output logic          ibf,
  output logic          ibf_irq,
  output logic          a20_sel,
  output logic          a20_out
);

  logic en, pending;

  wire wr_ok   = hwr_valid && lreset_n;
  wire wr_cmd  = wr_ok && (hwr_addr == AW'(CMD_PORT));
  wire wr_dat  = wr_ok && (hwr_addr == AW'(DATA_PORT));
  wire seq_cmd = wr_cmd && en && (hwr_data == A20_CMD);
  wire seq_dat = wr_dat && en && pending;
  wire normal  = (wr_cmd && !seq_cmd) || (wr_dat && !seq_dat);

  assign cpu_rdata = {{(DW-1){1'b0}}, en};
  assign a20_sel   = en && lreset_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else if (cpu_wr) en <= cpu_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      a20_out <= 1'b1;
    end else if (!lreset_n) begin
      pending <= 1'b0;
      a20_out <= 1'b0;
    end else begin
      if (!en || wr_cmd) pending <= seq_cmd;
      else if (seq_dat) pending <= 1'b0;
      if (seq_dat) a20_out <= hwr_data[A20_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibuf_data <= '0;
      cmd_flag  <= 1'b0;
      ibf       <= 1'b0;
      ibf_irq   <= 1'b0;
    end else begin
      if (wr_cmd || wr_dat) begin
        ibuf_data <= hwr_data;
        cmd_flag  <= wr_cmd;
      end
      ibf_irq <= normal;
      if (normal) ibf <= 1'b1;
      else if (cpu_ibuf_rd) ibf <= 1'b0;
    end
  end

endmodule

module kbc_gate_a20_chk #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] CMD_PORT = 16'h0064,
  parameter logic [7:0]  A20_CMD  = 8'hD1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lreset_n,
  input logic          hwr_valid,
  input logic [AW-1:0] hwr_addr,
  input logic [DW-1:0] hwr_data,
  input logic [DW-1:0] cpu_rdata,
  input logic          cmd_flag,
  input logic          ibf,
  input logic          ibf_irq,
  input logic          a20_out
);

  assert_a20_low_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lreset_n |=> !a20_out);

  assert_irq_with_ibf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_irq |-> ibf);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ibf_irq |=> !ibf_irq || $past(hwr_valid));

  assert_seq_cmd_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr_valid && lreset_n && cpu_rdata[0] && hwr_addr == AW'(CMD_PORT) && hwr_data == A20_CMD)
    |=> !ibf_irq && cmd_flag);

  assert_a20_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lreset_n && !hwr_valid) |=> $stable(a20_out) || !lreset_n);

endmodule

bind kbc_gate_a20 kbc_gate_a20_chk #(.AW(AW), .DW(DW), .CMD_PORT(CMD_PORT), .A20_CMD(A20_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .lreset_n(lreset_n), .hwr_valid(hwr_valid),
  .hwr_addr(hwr_addr), .hwr_data(hwr_data), .cpu_rdata(cpu_rdata),
  .cmd_flag(cmd_flag), .ibf(ibf), .ibf_irq(ibf_irq), .a20_out(a20_out)
);

// File: tb/tb_kbc_gate_a20.sv
module tb_kbc_gate_a20;
  logic clk = 1'b0, rst_n = 1'b0, lreset_n = 1'b1;
  logic hwr_valid = 1'b0, cpu_wr = 1'b0, cpu_ibuf_rd = 1'b0;
  logic [15:0] hwr_addr = '0;
  logic [7:0] hwr_data = '0, cpu_wdata = '0;
  logic [7:0] cpu_rdata, ibuf_data;
  logic cmd_flag, ibf, ibf_irq, a20_sel, a20_out;

  int checks = 0, errors = 0;
  bit m_en, m_pend, m_a20, m_ibf, m_irq, m_cmd;
  logic [7:0] m_buf;

  always #5 clk = ~clk;

  kbc_gate_a20 dut (.*);

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk(a20_out == m_a20, "R4 R6 R8 R9 a20_out", a20_out, m_a20);
    chk(a20_sel == (m_en && lreset_n), "R3 a20_sel", a20_sel, m_en && lreset_n);
    chk(cpu_rdata == {7'd0, m_en}, "R2 cpu_rdata", cpu_rdata, {7'd0, m_en});
    chk(ibf == m_ibf, "R5 R7 R10 ibf", ibf, m_ibf);
    chk(ibf_irq == m_irq, "R5 R7 ibf_irq", ibf_irq, m_irq);
    chk(cmd_flag == m_cmd, "R5 cmd_flag", cmd_flag, m_cmd);
    chk(ibuf_data == m_buf, "R5 R11 ibuf_data", ibuf_data, m_buf);
  endtask

  function automatic void model(bit wr, logic [15:0] a, logic [7:0] d, bit rd,
                                bit cw, logic [7:0] cd, bit lr);
    bit norm = 0;
    if (!lr) begin m_a20 = 0; m_pend = 0; end
    else begin
      if (!m_en) m_pend = 0;
      if (wr && a == 16'h0064) begin
        m_buf = d; m_cmd = 1;
        if (m_en && d == 8'hD1) m_pend = 1; else begin m_pend = 0; norm = 1; end
      end else if (wr && a == 16'h0060) begin
        m_buf = d; m_cmd = 0;
        if (m_en && m_pend) begin m_a20 = d[1]; m_pend = 0; end else norm = 1;
      end
    end
    m_irq = norm;
    if (norm) m_ibf = 1; else if (rd) m_ibf = 0;
    if (cw) m_en = cd[0];
  endfunction

  task automatic step(bit wr, logic [15:0] a, logic [7:0] d, bit rd,
                      bit cw, logic [7:0] cd, bit lr);
    @(negedge clk);
    hwr_valid = wr && lr; hwr_addr = a; hwr_data = d;
    cpu_ibuf_rd = rd; cpu_wr = cw; cpu_wdata = cd; lreset_n = lr;
    model(wr && lr, a, d, rd, cw, cd, lr);
    @(negedge clk);
    hwr_valid = 0; cpu_ibuf_rd = 0; cpu_wr = 0;
    compare();
  endtask

  task automatic hw(logic [15:0] a, logic [7:0] d); step(1, a, d, 0, 0, 0, 1); endtask

  initial begin
    void'($urandom(32'h5eed_a20));
    m_en = 0; m_pend = 0; m_a20 = 1; m_ibf = 0; m_irq = 0; m_cmd = 0; m_buf = 0;
    repeat (3) @(negedge clk);
    compare();                                // R1 reset values
    rst_n = 1;
    step(0, 0, 0, 0, 1, 8'hFF, 1);            // R2 upper bits read 0
    hw(16'h0064, 8'hD1); hw(16'h0060, 8'h00); // R4 a20 -> 0, R5 silent
    hw(16'h0060, 8'h02);                      // R6 plain data, a20 held
    step(0, 0, 0, 1, 0, 0, 1);                // R10 read clears ibf
    hw(16'h0064, 8'hD1); hw(16'h0060, 8'h02); // R4 a20 -> 1
    hw(16'h0064, 8'hD1); hw(16'h0064, 8'hAA); hw(16'h0060, 8'h00); // R7 cancel
    hw(16'h0064, 8'hD1); step(1, 16'h0060, 8'h00, 1, 0, 0, 1);     // R10 no set
    hw(16'h0070, 8'h55);                      // R11 other port ignored
    hw(16'h0064, 8'hD1);
    step(0, 0, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);          // R9
    step(0, 0, 0, 0, 0, 0, 1); hw(16'h0060, 8'h02);                // R9 pending lost
    step(0, 0, 0, 0, 1, 8'h00, 1);
    hw(16'h0064, 8'hD1); hw(16'h0060, 8'h02); // R8 disabled
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d = $urandom_range(0, 255);
      case (op)
        0, 1: hw(16'h0064, 8'hD1);
        2:    hw(16'h0064, d);
        3, 4: hw(16'h0060, d);
        5:    hw(16'(32'h0050 + $urandom_range(0, 47)), d);
        6:    step(0, 0, 0, 1, 0, 0, 1);
        7:    step(0, 0, 0, 0, 1, d, 1);
        8:    step(1, 16'h0060, d, 0, 0, 0, 0);
        default: step(1, 16'h0060, d, 1, 0, 0, 1);
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule